// File: doc/BRIEF.md
# Two-Wire Bus Slave Parallel Port Expander

This block is a slave on a two-wire serial bus that connects the bus to one 8-bit parallel port. The clock and data lines are brought into a fast system clock domain, synchronized and cleaned by a short majority filter. The block then decodes start and stop conditions, collects a 7-bit slave address with a direction bit, and acknowledges when the address is its own. The address is a fixed 4-bit prefix followed by three strap inputs. A select input chooses between two prefixes, so two groups of eight expanders can share one bus.

The port has no register pointer. In a write, every data byte replaces the port output register, and a one-cycle write strobe marks each update. In a read, the port pins are sampled during the acknowledge clock that comes before each byte, and a one-cycle read strobe marks each sample. The byte is then shifted out MSB first. The data line is never driven high: the block only outputs a pull-low enable for an external open-drain pad. A master can run any number of bytes in one transfer, end a read with a not-acknowledge, or start again with a repeated start.

Top module: `i2c_port_expander`

## Requirements
- R1: A fall of SDA while SCL is high is a START and a rise of SDA while SCL is high is a STOP. A STOP in the middle of a byte ends the transfer and leaves the port output register unchanged.
- R2: The block responds to the 7-bit address {4'b0100, addr_pins[2:0]} when alt_prefix is 0, and to {4'b0111, addr_pins[2:0]} when alt_prefix is 1. Bits are received MSB first, and the eighth bit is the direction: 1 is read, 0 is write.
- R3: A pulse of one system clock on SCL or on SDA is rejected by the synchronizer and the 3-sample majority filter. It does not change the received data and it creates no START or STOP.
- R4: After a matching address and after every received write byte, sda_pull is 1 for the ninth (acknowledge) clock. sda_pull only rises after the filtered SCL has gone low.
- R5: In a write, each received byte replaces port_out on the SCL fall that ends its acknowledge bit. A single transfer may carry several bytes.
- R6: wr_strobe pulses for exactly one cycle with each port_out update. port_out changes at no other time, and wr_strobe and rd_strobe are never high together.
- R7: After an address mismatch, sda_pull stays 0 and port_out is unchanged until the next START.
- R8: Reset sets port_out to all ones and sets sda_pull, wr_strobe and rd_strobe to 0.
- R9: In a read, port_in is captured on the SCL rise of the acknowledge bit before each byte, and rd_strobe pulses then. The byte is sent MSB first, and each byte is a fresh sample.
- R10: When the master does not acknowledge a read byte (SDA high on the ninth clock), the block releases SDA and drives nothing until the next START.
- R11: A repeated START, with no STOP before it, begins a new address phase. A read may follow a write in this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND level) |
| addr_pins | input | 3 | Strap inputs for the low three address bits |
| alt_prefix | input | 1 | Selects address prefix 0111 instead of 0100 |
| port_in | input | 8 | Levels currently on the port pins |
| port_out | output | 8 | Port output register |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_strobe | output | 1 | One-cycle pulse when port_out is loaded |
| rd_strobe | output | 1 | One-cycle pulse when port_in is sampled |

## Verification
The checker tests these properties on every cycle: the reset values, that sda_pull only rises after the filtered SCL has fallen, that port_out changes only together with a one-cycle write strobe, that the two strobes are never high together, and that a read strobe only follows a high SCL. Only the directed scenarios can show the rest. These are address matching under both prefixes and a mismatch, byte values in write and read order, a fresh port sample for each read byte, release after a not-acknowledge, rejection of single-cycle glitches, a STOP that aborts a byte, and a repeated start.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
  localparam int BYTE_W      = 8;
  localparam int SADDR_W     = 7;
  localparam int PIN_ADDR_W  = 3;
  localparam int PREFIX_W    = SADDR_W - PIN_ADDR_W;
  localparam logic [PREFIX_W-1:0] PREFIX_STD = 4'b0100;
  localparam logic [PREFIX_W-1:0] PREFIX_ALT = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } slave_state_t;
endpackage

// File: rtl/ioexp_line_filter.sv
module ioexp_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW   = $clog2(TAPS + 1);
  localparam int HALF = TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        hist_q;
  logic [CW-1:0]          ones;
  logic                   major;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) ones = ones + CW'(hist_q[i]);
    major = (ones > CW'(HALF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      dout   <= major;
    end
  end
endmodule

// File: rtl/ioexp_bus_events.sv
module ioexp_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
  import ioexp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [PIN_ADDR_W-1:0] addr_pins,
  input  logic                  alt_prefix,
  input  logic [BYTE_W-1:0]     port_in,
  output logic [BYTE_W-1:0]     port_out,
  output logic                  sda_pull,
  output logic                  wr_strobe,
  output logic                  rd_strobe
);
  localparam int NLINES = 2;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [NLINES-1:0] raw_lines, flt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    ioexp_line_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(flt_lines[g])
    );
  end

  assign scl_f = flt_lines[0];
  assign sda_f = flt_lines[1];

  ioexp_bus_events u_events (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  slave_state_t         st;
  logic [CNT_W-1:0]     cnt;
  logic [BYTE_W-1:0]    sh;
  logic                 rw;
  logic [SADDR_W-1:0]   own_addr;

  assign own_addr = {(alt_prefix ? PREFIX_ALT : PREFIX_STD), addr_pins};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      rw        <= 1'b0;
      sda_pull  <= 1'b0;
      port_out  <= '1;
      wr_strobe <= 1'b0;
      rd_strobe <= 1'b0;
    end else begin
      wr_strobe <= 1'b0;
      rd_strobe <= 1'b0;
      if (start_ev) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (sh[BYTE_W-1:1] == own_addr) begin
                st       <= ST_AACK;
                rw       <= sh[0];
                sda_pull <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_rise && rw) begin
              sh        <= port_in;
              rd_strobe <= 1'b1;
            end else if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                st       <= ST_RDAT;
                sda_pull <= ~sh[BYTE_W-1];
              end else begin
                st       <= ST_WDAT;
                sda_pull <= 1'b0;
              end
            end
          end
          ST_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              st       <= ST_WACK;
              sda_pull <= 1'b1;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              port_out  <= sh;
              wr_strobe <= 1'b1;
              sda_pull  <= 1'b0;
              cnt       <= '0;
              st        <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                st       <= ST_RACK;
                sda_pull <= 1'b0;
              end else begin
                sh       <= {sh[BYTE_W-2:0], 1'b0};
                sda_pull <= ~sh[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_f) begin
                st <= ST_IDLE;
              end else begin
                sh        <= port_in;
                rd_strobe <= 1'b1;
              end
            end else if (scl_fall) begin
              st       <= ST_RDAT;
              cnt      <= '0;
              sda_pull <= ~sh[BYTE_W-1];
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ioexp_checker.sv
module ioexp_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         scl_flt,
  input logic         sda_pull,
  input logic         wr_strobe,
  input logic         rd_strobe,
  input logic [W-1:0] port_out
);
  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (port_out == '1 && !sda_pull && !wr_strobe && !rd_strobe));

  // R4: the pull-low enable only turns on after SCL has been seen low
  assert_pull_after_low_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !$past(scl_flt));

  assert_out_with_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(port_out) |-> wr_strobe);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr_strobe && rd_strobe));

  assert_wr_single_R6: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !wr_strobe);

  assert_rd_after_high_R9: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> $past(scl_flt));
endmodule

bind i2c_port_expander ioexp_checker #(.W(ioexp_pkg::BYTE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_flt  (scl_f),
  .sda_pull (sda_pull),
  .wr_strobe(wr_strobe),
  .rd_strobe(rd_strobe),
  .port_out (port_out)
);

// File: tb/i2c_port_expander_tb.sv
module i2c_port_expander_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QTR  = 10;
  localparam int HIGH = 20;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] addr_pins = 3'b101;
  logic alt_prefix = 1'b0;
  logic [7:0] port_in = 8'h00;
  logic [7:0] port_out;
  logic sda_pull, wr_strobe, rd_strobe;
  logic sda_line;

  int n_checks = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0;
  bit pull_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  i2c_port_expander dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .addr_pins(addr_pins), .alt_prefix(alt_prefix), .port_in(port_in),
    .port_out(port_out), .sda_pull(sda_pull),
    .wr_strobe(wr_strobe), .rd_strobe(rd_strobe)
  );

  always @(posedge clk) begin
    if (wr_strobe) wr_cnt++;
    if (rd_strobe) rd_cnt++;
    if (sda_pull) pull_seen = 1;
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clks(QTR);
    m_scl = 1'b1; wait_clks(HIGH);
    m_sda = 1'b0; wait_clks(HIGH);
    m_scl = 1'b0; wait_clks(QTR);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clks(QTR);
    m_scl = 1'b1; wait_clks(HIGH);
    m_sda = 1'b1; wait_clks(HIGH);
  endtask

  task automatic send_bit(input bit b, input bit glitch);
    m_sda = b;
    if (glitch) begin
      wait_clks(3); m_scl = 1'b1; wait_clks(1); m_scl = 1'b0; wait_clks(QTR - 4);
    end else wait_clks(QTR);
    m_scl = 1'b1;
    if (glitch && b) begin
      wait_clks(HIGH/2); m_sda = 1'b0; wait_clks(1); m_sda = 1'b1; wait_clks(HIGH/2 - 1);
    end else wait_clks(HIGH);
    m_scl = 1'b0; wait_clks(QTR);
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; wait_clks(QTR);
    m_scl = 1'b1; wait_clks(HIGH/2);
    b = sda_line; wait_clks(HIGH/2);
    m_scl = 1'b0; wait_clks(QTR);
  endtask

  task automatic put_byte(input logic [7:0] v, input bit glitch, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic take_byte(input bit nack, input logic [7:0] next_port, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    port_in = next_port;
    send_bit(nack, 1'b0);
  endtask

  task automatic t_reset();
    check(port_out == 8'hFF, "R8 port_out", port_out, 8'hFF);
    check(!sda_pull && !wr_strobe && !rd_strobe, "R8 outputs idle",
          {sda_pull, wr_strobe, rd_strobe}, 0);
  endtask

  task automatic t_write_multi();
    bit ack; int w0 = wr_cnt;
    bus_start();
    put_byte(8'h4A, 1'b0, ack); check(ack, "R2/R4 address ack", ack, 1);
    put_byte(8'h5A, 1'b0, ack); check(ack, "R4 data ack", ack, 1);
    check(port_out == 8'h5A, "R5 first byte", port_out, 8'h5A);
    put_byte(8'h00, 1'b0, ack);
    check(port_out == 8'h00, "R5 second byte", port_out, 8'h00);
    put_byte(8'hC3, 1'b0, ack);
    check(port_out == 8'hC3, "R5 third byte", port_out, 8'hC3);
    bus_stop();
    check(wr_cnt - w0 == 3, "R6 one strobe per byte", wr_cnt - w0, 3);
  endtask

  task automatic t_mismatch();
    bit ack; int w0 = wr_cnt;
    pull_seen = 0;
    bus_start();
    put_byte(8'h4C, 1'b0, ack); check(!ack, "R7 mismatch no ack", ack, 0);
    put_byte(8'h11, 1'b0, ack); check(!ack, "R7 data after mismatch", ack, 0);
    bus_stop();
    check(!pull_seen, "R7 never drove", pull_seen, 0);
    check(port_out == 8'hC3 && wr_cnt == w0, "R7 port unchanged", port_out, 8'hC3);
  endtask

  task automatic t_alt_prefix();
    bit ack;
    alt_prefix = 1'b1;
    bus_start();
    put_byte(8'h4A, 1'b0, ack); check(!ack, "R2 std address ignored with alt", ack, 0);
    bus_stop();
    bus_start();
    put_byte(8'h7A, 1'b0, ack); check(ack, "R2 alt address ack", ack, 1);
    put_byte(8'h81, 1'b0, ack);
    bus_stop();
    check(port_out == 8'h81, "R2 alt write", port_out, 8'h81);
    alt_prefix = 1'b0;
  endtask

  task automatic t_read();
    bit ack; logic [7:0] v; int r0 = rd_cnt;
    port_in = 8'hA6;
    bus_start();
    put_byte(8'h4B, 1'b0, ack); check(ack, "R9 read address ack", ack, 1);
    take_byte(1'b0, 8'h3C, v);
    check(v == 8'hA6, "R9 first read", v, 8'hA6);
    take_byte(1'b1, 8'hFF, v);
    check(v == 8'h3C, "R9 fresh sample", v, 8'h3C);
    wait_clks(QTR);
    check(!sda_pull, "R10 released after nack", sda_pull, 0);
    check(rd_cnt - r0 == 2, "R9 read strobes", rd_cnt - r0, 2);
    bus_stop();
  endtask

  task automatic t_glitch();
    bit ack;
    bus_start();
    put_byte(8'h4A, 1'b1, ack); check(ack, "R3 glitched address ack", ack, 1);
    put_byte(8'hB5, 1'b1, ack);
    bus_stop();
    check(port_out == 8'hB5, "R3 glitches rejected", port_out, 8'hB5);
  endtask

  task automatic t_abort();
    bit ack; int w0 = wr_cnt;
    bus_start();
    put_byte(8'h4A, 1'b0, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
    bus_stop();
    check(port_out == 8'hB5 && wr_cnt == w0, "R1 stop aborts byte", port_out, 8'hB5);
    bus_start();
    put_byte(8'h4A, 1'b0, ack);
    put_byte(8'h77, 1'b0, ack);
    bus_stop();
    check(port_out == 8'h77, "R1 next transfer after abort", port_out, 8'h77);
  endtask

  task automatic t_restart();
    bit ack; logic [7:0] v;
    bus_start();
    put_byte(8'h4A, 1'b0, ack);
    put_byte(8'h99, 1'b0, ack);
    port_in = 8'h5E;
    bus_start();
    put_byte(8'h4B, 1'b0, ack); check(ack, "R11 restart address ack", ack, 1);
    take_byte(1'b1, 8'h00, v);
    bus_stop();
    check(v == 8'h5E, "R11 read after restart", v, 8'h5E);
    check(port_out == 8'h99, "R11 write before restart", port_out, 8'h99);
  endtask

  initial begin
    wait_clks(5);
    rst = 1'b0;
    wait_clks(5);
    t_reset();
    t_write_multi();
    t_mismatch();
    t_alt_prefix();
    t_read();
    t_glitch();
    t_abort();
    t_restart();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule